// File: doc/BRIEF.md
# CAN controller mode handshake unit

This unit sits beside the protocol engine of a CAN controller and decides which operating mode the controller is in. Software asks for the initialization mode with a request level and for the sleep mode with a request bit held inside the unit. The unit answers each request with an acknowledge bit. Entering initialization sends a single-cycle abort to the transmit and receive engines. In the same cycle it sends a clear strobe to the control, flag and interrupt-enable registers. The unit also produces two write-permission levels: one for the configuration registers, and one for the ordinary control and flag bits.

On the bus side the unit watches the sampled receive bit, which is qualified by a once-per-bit strobe. After initialization it decides when the node counts as synchronized to the bus again. A node that was healthy at exit needs one run of eleven consecutive recessive bits. A node that was bus-off at exit needs 128 such runs. The sleep request is interlocked with its acknowledge. If wake-up is enabled, dominant traffic on the bus withdraws the request.

Top module: `can_mode_ctrl`

## Requirements
- R1: After reset, `init_ack_o`, `slp_req_o`, `slp_ack_o`, `xfer_abort_o`, `regs_clr_o`, `cfg_wr_en_o` and `bus_sync_o` are 0, and `ctl_wr_en_o` is 1.
- R2: `init_ack_o` takes the value that `init_req_i` had in the previous cycle, both when the request rises and when it falls.
- R3: `xfer_abort_o` and `regs_clr_o` are high for exactly one cycle, and that cycle is the one in which `init_ack_o` first reads 1.
- R4: `cfg_wr_en_o` is 1 exactly when `init_req_i` and `init_ack_o` are both 1.
- R5: `ctl_wr_en_o` is 1 exactly when `init_req_i` and `init_ack_o` are both 0.
- R6: `bus_sync_o` is 0 in any cycle that follows a cycle in which `init_req_i` or `init_ack_o` was 1. Outside initialization, a node that was not bus-off raises `bus_sync_o` one cycle after the strobed bit that completes 11 consecutive recessive bits (`rx_bit_i` = 1 is recessive, 0 is dominant). Once raised, it stays high until initialization is entered again.
- R7: A strobed dominant bit restarts the recessive run from zero. Cycles with `bit_stb_i` = 0 neither extend nor break a run.
- R8: `bus_off_i` is sampled in the cycle with `init_req_i` = 0 and `init_ack_o` = 1. If it is 1, `bus_sync_o` rises only one cycle after the 128th completed run of 11 recessive bits. Each completed run starts a fresh one.
- R9: A sleep write with data 1 sets `slp_req_o` on the next cycle. A sleep write with data 0 clears it on the next cycle only if `slp_req_o` and `slp_ack_o` are both 1; otherwise it is ignored. When data 1 and a wake event meet in the same cycle, the write wins.
- R10: `slp_ack_o` becomes 1 one cycle after a cycle with `slp_req_o` = 1 and `frame_busy_i` = 0, and it stays 1 while the request stays. It becomes 0 one cycle after a cycle with `slp_req_o` = 0.
- R11: With `wake_en_i` = 1 and `slp_ack_o` = 1, a strobed dominant bit clears `slp_req_o` on the next cycle. With `wake_en_i` = 0 the same bit has no effect.
- R12: Entering or leaving initialization leaves `slp_req_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| init_req_i | input | 1 | Initialization request level from the control register |
| slp_wr_i | input | 1 | Write strobe for the sleep request bit |
| slp_wdata_i | input | 1 | Data written to the sleep request bit |
| wake_en_i | input | 1 | Lets bus activity withdraw a sleep request |
| rx_bit_i | input | 1 | Sampled receive bit, 1 recessive, 0 dominant |
| bit_stb_i | input | 1 | Marks the cycle in which `rx_bit_i` holds a new bit |
| bus_off_i | input | 1 | Bus-off state from the error logic |
| frame_busy_i | input | 1 | A frame is being sent or received |
| init_ack_o | output | 1 | Initialization acknowledge |
| slp_req_o | output | 1 | Sleep request bit |
| slp_ack_o | output | 1 | Sleep acknowledge |
| xfer_abort_o | output | 1 | Single-cycle abort to the transmit and receive engines |
| regs_clr_o | output | 1 | Single-cycle clear of the control, flag and interrupt-enable registers |
| cfg_wr_en_o | output | 1 | Configuration registers may be written |
| ctl_wr_en_o | output | 1 | Ordinary control and flag bits may be written |
| bus_sync_o | output | 1 | Node is synchronized to the bus |

## Verification
Each registered result is due one clock after the edge that samples its cause. This covers the acknowledge bits, the abort and clear pulses, the sleep request and `bus_sync_o`. The two write-permission levels follow their inputs in the same cycle. The bench drives stimulus on the falling edge. A behavioural model updates at the rising edge from the inputs held across that edge. One time unit later, before any input moves, every output is compared with the model, so each comparison falls in the cycle where the requirement places the change. The bus-off case runs all 128 runs, with a broken run inside them, and checks that `bus_sync_o` stays low up to the final strobe.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;

   // recessive bits in a row that count as one idle run
   localparam int unsigned IDLE_RUN_BITS = 11;
   // idle runs demanded after a bus-off exit
   localparam int unsigned BOFF_IDLE_RUNS = 128;

   typedef enum logic [0:0] {
      SY_SEEK = 1'b0,
      SY_DONE = 1'b1
   } sync_state_e;

endpackage

// File: rtl/can_init_hs.sv
module can_init_hs (
   input  logic clk,
   input  logic rst_n,
   input  logic init_req_i,
   output logic init_ack_o,
   output logic xfer_abort_o,
   output logic regs_clr_o,
   output logic cfg_wr_en_o,
   output logic ctl_wr_en_o,
   output logic in_init_o,
   output logic exit_o
);

   logic ack_q;
   logic enter_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_q   <= 1'b0;
         enter_q <= 1'b0;
      end else begin
         ack_q   <= init_req_i;
         enter_q <= init_req_i & ~ack_q;
      end
   end

   assign init_ack_o   = ack_q;
   assign xfer_abort_o = enter_q;
   assign regs_clr_o   = enter_q;
   assign cfg_wr_en_o  = init_req_i & ack_q;
   assign ctl_wr_en_o  = ~init_req_i & ~ack_q;
   assign in_init_o    = init_req_i | ack_q;
   assign exit_o       = ~init_req_i & ack_q;

   // R2
   ack_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      init_req_i |=> init_ack_o);
   // R2
   ack_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !init_req_i |=> !init_ack_o);
   // R3
   abort_in_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_abort_o |-> init_ack_o);
   // R3
   abort_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_abort_o |=> !xfer_abort_o);

endmodule

// File: rtl/can_sleep_hs.sv
module can_sleep_hs (
   input  logic clk,
   input  logic rst_n,
   input  logic slp_wr_i,
   input  logic slp_wdata_i,
   input  logic wake_en_i,
   input  logic bit_stb_i,
   input  logic rx_bit_i,
   input  logic frame_busy_i,
   output logic slp_req_o,
   output logic slp_ack_o
);

   logic req_q;
   logic ack_q;
   logic set_w;
   logic clr_w;
   logic wake_w;

   assign set_w  = slp_wr_i & slp_wdata_i;
   assign clr_w  = slp_wr_i & ~slp_wdata_i & req_q & ack_q;
   assign wake_w = wake_en_i & ack_q & bit_stb_i & ~rx_bit_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q <= 1'b0;
         ack_q <= 1'b0;
      end else begin
         if (set_w)
            req_q <= 1'b1;
         else if (clr_w || wake_w)
            req_q <= 1'b0;
         ack_q <= req_q & (ack_q | ~frame_busy_i);
      end
   end

   assign slp_req_o = req_q;
   assign slp_ack_o = ack_q;

   // R9
   slp_clr_interlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(slp_req_o) |-> $past(slp_ack_o));
   // R10
   slp_ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(slp_ack_o) |-> $past(!frame_busy_i));
   // R10
   slp_ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !slp_req_o |=> !slp_ack_o);

endmodule

// File: rtl/can_bus_sync.sv
module can_bus_sync
   import can_mode_pkg::*;
#(
   parameter int unsigned RUN_LEN   = IDLE_RUN_BITS,
   parameter int unsigned BOFF_RUNS = BOFF_IDLE_RUNS
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_init_i,
   input  logic exit_i,
   input  logic bus_off_i,
   input  logic bit_stb_i,
   input  logic rx_bit_i,
   output logic sync_o
);

   localparam int unsigned RUN_W = (RUN_LEN > 2) ? $clog2(RUN_LEN) : 1;
   localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(RUN_LEN - 1);

   generate
      if (RUN_LEN < 2) begin : g_bad_run
         $error("RUN_LEN must be at least 2");
      end
      if (BOFF_RUNS < 1) begin : g_bad_boff
         $error("BOFF_RUNS must be at least 1");
      end
   endgenerate

   sync_state_e      st_q;
   logic [RUN_W-1:0] run_q;
   logic             boff_q;
   logic             seeking;
   logic             run_done;
   logic             occ_last;

   assign seeking  = (st_q == SY_SEEK) & ~in_init_i;
   assign run_done = seeking & bit_stb_i & rx_bit_i & (run_q == RUN_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         run_q <= '0;
      else if (in_init_i)
         run_q <= '0;
      else if (seeking && bit_stb_i) begin
         if (!rx_bit_i || run_done)
            run_q <= '0;
         else
            run_q <= run_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         boff_q <= 1'b0;
      else if (exit_i)
         boff_q <= bus_off_i;
   end

   generate
      if (BOFF_RUNS > 1) begin : g_occ
         localparam int unsigned OCC_W = $clog2(BOFF_RUNS);
         localparam logic [OCC_W-1:0] OCC_LAST = OCC_W'(BOFF_RUNS - 1);
         logic [OCC_W-1:0] occ_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               occ_q <= '0;
            else if (in_init_i)
               occ_q <= '0;
            else if (run_done && boff_q)
               occ_q <= (occ_q == OCC_LAST) ? '0 : occ_q + 1'b1;
         end

         assign occ_last = (occ_q == OCC_LAST);

         // R8
         occ_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (occ_q <= OCC_LAST));
      end else begin : g_no_occ
         assign occ_last = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         st_q <= SY_SEEK;
      else if (in_init_i)
         st_q <= SY_SEEK;
      else if (run_done && (!boff_q || occ_last))
         st_q <= SY_DONE;
   end

   assign sync_o = (st_q == SY_DONE);

   // R6
   sync_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_init_i |=> !sync_o);
   // R6
   sync_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_o && !in_init_i) |=> sync_o);
   // R7
   run_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q <= RUN_LAST));
   // R7
   dominant_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seeking && bit_stb_i && !rx_bit_i) |=> (run_q == '0));

endmodule

// File: rtl/can_mode_ctrl.sv
module can_mode_ctrl
   import can_mode_pkg::*;
#(
   parameter int unsigned RUN_LEN   = IDLE_RUN_BITS,
   parameter int unsigned BOFF_RUNS = BOFF_IDLE_RUNS
) (
   input  logic clk,
   input  logic rst_n,
   input  logic init_req_i,
   input  logic slp_wr_i,
   input  logic slp_wdata_i,
   input  logic wake_en_i,
   input  logic rx_bit_i,
   input  logic bit_stb_i,
   input  logic bus_off_i,
   input  logic frame_busy_i,
   output logic init_ack_o,
   output logic slp_req_o,
   output logic slp_ack_o,
   output logic xfer_abort_o,
   output logic regs_clr_o,
   output logic cfg_wr_en_o,
   output logic ctl_wr_en_o,
   output logic bus_sync_o
);

   logic in_init;
   logic init_exit;

   can_init_hs u_init (
      .clk          (clk),
      .rst_n        (rst_n),
      .init_req_i   (init_req_i),
      .init_ack_o   (init_ack_o),
      .xfer_abort_o (xfer_abort_o),
      .regs_clr_o   (regs_clr_o),
      .cfg_wr_en_o  (cfg_wr_en_o),
      .ctl_wr_en_o  (ctl_wr_en_o),
      .in_init_o    (in_init),
      .exit_o       (init_exit)
   );

   can_sleep_hs u_sleep (
      .clk          (clk),
      .rst_n        (rst_n),
      .slp_wr_i     (slp_wr_i),
      .slp_wdata_i  (slp_wdata_i),
      .wake_en_i    (wake_en_i),
      .bit_stb_i    (bit_stb_i),
      .rx_bit_i     (rx_bit_i),
      .frame_busy_i (frame_busy_i),
      .slp_req_o    (slp_req_o),
      .slp_ack_o    (slp_ack_o)
   );

   can_bus_sync #(
      .RUN_LEN   (RUN_LEN),
      .BOFF_RUNS (BOFF_RUNS)
   ) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_init_i (in_init),
      .exit_i    (init_exit),
      .bus_off_i (bus_off_i),
      .bit_stb_i (bit_stb_i),
      .rx_bit_i  (rx_bit_i),
      .sync_o    (bus_sync_o)
   );

   // R4
   wr_gate_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_wr_en_o && ctl_wr_en_o));
   // R12
   slp_keep_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (regs_clr_o && !slp_wr_i && !slp_ack_o) |=> $stable(slp_req_o));

endmodule

// File: tb/sim_can_mode_ctrl.sv
`timescale 1ns/1ps
module sim_can_mode_ctrl;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic init_req = 1'b0, slp_wr = 1'b0, slp_wd = 1'b0, wake_en = 1'b0;
   logic rx = 1'b1, stb = 1'b0, boff = 1'b0, busy = 1'b0;
   logic init_ack, slp_req, slp_ack, abort_p, clr_p, cfg_en, ctl_en, sync;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   can_mode_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .init_req_i(init_req), .slp_wr_i(slp_wr),
      .slp_wdata_i(slp_wd), .wake_en_i(wake_en), .rx_bit_i(rx), .bit_stb_i(stb),
      .bus_off_i(boff), .frame_busy_i(busy), .init_ack_o(init_ack),
      .slp_req_o(slp_req), .slp_ack_o(slp_ack), .xfer_abort_o(abort_p),
      .regs_clr_o(clr_p), .cfg_wr_en_o(cfg_en), .ctl_wr_en_o(ctl_en),
      .bus_sync_o(sync)
   );

   // behavioural reference state
   int  m_ack = 0, m_pulse = 0, m_sreq = 0, m_sack = 0;
   int  m_run = 0, m_runs_done = 0, m_sync = 0, m_boff = 0;

   task automatic chk(input string req, input string nm, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, nm, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      int n_ack, n_pulse, n_sreq, n_sack;
      if (rst_n) begin
         n_ack   = init_req;
         n_pulse = (init_req && !m_ack) ? 1 : 0;
         n_sreq  = m_sreq;
         if (slp_wr && slp_wd) n_sreq = 1;
         else if (slp_wr && !slp_wd && m_sreq == 1 && m_sack == 1) n_sreq = 0;
         else if (wake_en && m_sack == 1 && stb && !rx) n_sreq = 0;
         n_sack  = (m_sreq == 1 && (m_sack == 1 || !busy)) ? 1 : 0;
         if (init_req || m_ack == 1) begin
            if (!init_req) m_boff = boff;
            m_run = 0; m_runs_done = 0; m_sync = 0;
         end else if (m_sync == 0 && stb) begin
            if (!rx) m_run = 0;
            else begin
               m_run++;
               if (m_run == 11) begin
                  m_run = 0;
                  m_runs_done++;
                  if (m_boff == 0 || m_runs_done == 128) m_sync = 1;
               end
            end
         end
         m_ack = n_ack; m_pulse = n_pulse; m_sreq = n_sreq; m_sack = n_sack;
         #1;
         chk("R2", "init_ack", init_ack, m_ack[0]);
         chk("R3", "xfer_abort", abort_p, m_pulse[0]);
         chk("R3", "regs_clr", clr_p, m_pulse[0]);
         chk("R4", "cfg_wr_en", cfg_en, init_req & m_ack[0]);
         chk("R5", "ctl_wr_en", ctl_en, !init_req & !m_ack[0]);
         chk("R6 R7 R8", "bus_sync", sync, m_sync[0]);
         chk("R9 R11 R12", "slp_req", slp_req, m_sreq[0]);
         chk("R10", "slp_ack", slp_ack, m_sack[0]);
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bits(input int n, input logic v);
      repeat (n) begin
         @(negedge clk); stb = 1'b1; rx = v;
      end
      @(negedge clk); stb = 1'b0; rx = 1'b1;
   endtask

   task automatic do_init(input logic boff_at_exit);
      @(negedge clk); init_req = 1'b1;
      idle(3);
      boff = boff_at_exit; init_req = 1'b0;
      idle(2);
      boff = 1'b0;
   endtask

   task automatic slp_write(input logic v);
      @(negedge clk); slp_wr = 1'b1; slp_wd = v;
      @(negedge clk); slp_wr = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      @(posedge clk); #1;
      // R1: reset state
      chk("R1", "init_ack", init_ack, 1'b0);
      chk("R1", "slp_req", slp_req, 1'b0);
      chk("R1", "slp_ack", slp_ack, 1'b0);
      chk("R1", "abort", abort_p, 1'b0);
      chk("R1", "cfg_wr_en", cfg_en, 1'b0);
      chk("R1", "ctl_wr_en", ctl_en, 1'b1);
      chk("R1", "bus_sync", sync, 1'b0);

      // R6: plain sync, with strobe gaps inside the run (R7)
      bits(6, 1'b1); idle(3); bits(5, 1'b1); idle(2);
      chk("R6", "bus_sync after 11", sync, 1'b1);

      // R2 R3 R4 R5: init entry and exit
      do_init(1'b0);
      bits(5, 1'b1); bits(1, 1'b0); bits(10, 1'b1);
      chk("R7", "bus_sync after broken run", sync, 1'b0);
      bits(1, 1'b1); idle(1);
      chk("R7", "bus_sync after full run", sync, 1'b1);

      // R8: bus-off exit needs 128 runs
      do_init(1'b1);
      for (int k = 0; k < 128; k++) begin
         if (k == 40) bits(7, 1'b1);
         if (k == 40) bits(1, 1'b0);
         if (k == 127) begin
            bits(10, 1'b1);
            chk("R8", "bus_sync before last bit", sync, 1'b0);
            bits(1, 1'b1);
         end else
            bits(11, 1'b1);
      end
      idle(1);
      chk("R8", "bus_sync after 128 runs", sync, 1'b1);

      // R9 R10: sleep under a busy frame, early clear ignored
      @(negedge clk); busy = 1'b1;
      slp_write(1'b1);
      slp_write(1'b0);
      idle(2);
      chk("R9", "early clear ignored", slp_req, 1'b1);
      chk("R10", "ack waits for idle", slp_ack, 1'b0);
      busy = 1'b0;
      idle(2);
      chk("R10", "ack after idle", slp_ack, 1'b1);
      // R12: init does not touch the sleep request
      do_init(1'b0);
      chk("R12", "slp_req across init", slp_req, 1'b1);
      // R11: dominant bit with wake disabled has no effect
      bits(2, 1'b0);
      chk("R11", "no wake when disabled", slp_req, 1'b1);
      slp_write(1'b0);
      idle(2);
      chk("R9", "clear after ack", slp_req, 1'b0);
      chk("R10", "ack dropped", slp_ack, 1'b0);

      // R11: wake-up clears request
      @(negedge clk); wake_en = 1'b1;
      slp_write(1'b1);
      idle(3);
      bits(1, 1'b0);
      idle(2);
      chk("R11", "wake cleared", slp_req, 1'b0);
      chk("R11", "wake ack drop", slp_ack, 1'b0);

      // R9: set and wake event in the same cycle, set wins
      slp_write(1'b1);
      idle(3);
      @(negedge clk); slp_wr = 1'b1; slp_wd = 1'b1; stb = 1'b1; rx = 1'b0;
      @(negedge clk); slp_wr = 1'b0; stb = 1'b0; rx = 1'b1;
      chk("R9", "set beats wake", slp_req, 1'b1);
      idle(4);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule